// File: doc/BRIEF.md
# Mixed-Radix Stage Address Sequencer

This block drives the two symbol memories of a multi-stage, memory-based FFT engine whose stages may each use a different small-DFT size. Software or a host state machine sets the number of stages and the radix of each stage. A start pulse then makes the block walk every stage in turn. For each stage it issues one read address per clock. The addresses are grouped so that the inputs of one small DFT come out back to back. Each read carries a twiddle index and the stage's radix, which the arithmetic module uses as its mode. Every read address comes back as a write address a fixed number of cycles later, on the other memory.

The two memories swap roles at every stage. Bank 0 holds the time-domain input buffer before the run. Stage s reads bank s mod 2 and writes the other bank, so the result of the final stage lies in bank (number of stages) mod 2. The transform size is the product of the configured radices. This covers 3780 points (radices 7,5,4,3,3,3) and the power-of-two sizes up to 8192 (radix-2 or radix-4 stages). Each memory word is 32 bits, with a 16-bit real part and a 16-bit imaginary part. That word width is the concern of the memories and the arithmetic modules, not of this block.

Top module: `mrfft_addr_ctrl`

## Requirements
- R1: While reset is asserted and after its release with no start, busy, done, rdEn and wrEn are all 0.
- R2: A start seen while idle captures cfgStages and cfgRadix. busy rises on the next cycle, and that same cycle carries the first read, at address 0 of bank 0.
- R3: In stage s, stride is the product of the radices of stages s+1 to the last, and span is radix(s) times stride. Read addresses are blockBase + pos + k*stride, where k runs fastest over 0..radix(s)-1, then pos over 0..stride-1, then blockBase over 0, span, 2*span and so on below the size N.
- R4: rdEn is high on exactly N consecutive cycles per stage, one address per clock, and never between stages.
- R5: Stage s reads bank s mod 2 (rdBank). Every write of stage s goes to the other bank (wrBank).
- R6: Each read is mirrored by a write: wrEn is 1 exactly 1+MOD_LAT cycles after the read, with wrAddr equal to that read address. wrEn is 0 otherwise.
- R7: After the last read of a stage, rdEn stays 0 for exactly 1+MOD_LAT cycles. The next stage's first read follows in the very next cycle.
- R8: twIdx equals k*pos for every read of a stage that is not the last one, and equals 0 on every read of the last stage.
- R9: During a read, stageIdx gives the zero-based stage number and stageRadix gives that stage's radix. The radix of stage j sits in cfgRadix bits [3j+2:3j] as a plain binary value (2, 3, 4, 5 or 7), and cfgStages holds the stage count (1..13).
- R10: done is a single-cycle pulse in the cycle after the final stage's last write. busy is 0 in that same cycle.
- R11: A start asserted while busy is ignored. The running sequence continues unchanged, even if the configuration inputs change.
- R12: Any radix list whose product is at most 2^ADDR_W gives a full run. This includes 3780 points as 7,5,4,3,3,3, 2048 as eleven radix-2 stages and 4096 as six radix-4 stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform (honoured only when idle) |
| cfgStages | input | STG_W | Number of stages |
| cfgRadix | input | 3*MAX_STAGES | Radix of each stage, 3 bits per stage |
| busy | output | 1 | A transform is in progress |
| done | output | 1 | One-cycle end-of-transform pulse |
| rdEn | output | 1 | Read strobe for the source memory |
| rdBank | output | 1 | Memory being read |
| rdAddr | output | ADDR_W | Read address |
| twIdx | output | ADDR_W | Twiddle index for this read |
| stageIdx | output | STG_W | Current stage number |
| stageRadix | output | 3 | Radix (arithmetic mode) of the current stage |
| wrEn | output | 1 | Write strobe for the destination memory |
| wrBank | output | 1 | Memory being written |
| wrAddr | output | ADDR_W | Write address |

## Verification
The hardest situation to reach is the seam between two stages. There, the last writes of one stage are still in flight while the roles of the memories flip and the stride changes. An off-by-one at that seam only shows when the radices on each side differ. The stimulus therefore runs mixed lists such as 3,5 and 4,3,2 and the full 7,5,4,3,3,3 schedule. The bench compares every cycle of read and write traffic against an arithmetic walk of the nested loops. A second start with a garbage configuration is injected in the middle of a run to show that it changes nothing.

// File: rtl/mrfft_pkg.sv
package mrfft_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_GAP
  } seqState_t;

  // strobes from the sequencing control to the address datapath
  typedef struct packed {
    logic issue;       // a read goes out this cycle
    logic finalStage;  // current stage is the last one
    logic bankSel;     // bank read in this stage
  } seqStrobe_t;

endpackage

// File: rtl/mrfft_stage_cfg.sv
module mrfft_stage_cfg #(
  parameter int ADDR_W     = 13,
  parameter int MAX_STAGES = 13,
  parameter int RAD_W      = 3,
  parameter int STG_W      = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        load,
  input  logic [STG_W-1:0]            cfgStages,
  input  logic [MAX_STAGES*RAD_W-1:0] cfgRadix,
  input  logic [STG_W-1:0]            stageSel,
  output logic [STG_W-1:0]            numStages,
  output logic [RAD_W-1:0]            curRadix,
  output logic [ADDR_W:0]             curStride,
  output logic [ADDR_W:0]             totalSize
);

  logic [STG_W-1:0]            stagesQ;
  logic [MAX_STAGES*RAD_W-1:0] radixQ;
  logic [RAD_W-1:0]            eff [MAX_STAGES];
  logic [ADDR_W:0]             strideTab [MAX_STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stagesQ <= '0;
      radixQ  <= '0;
    end else if (load) begin
      stagesQ <= cfgStages;
      radixQ  <= cfgRadix;
    end
  end

  // unused stage slots count as radix 1 so the products ignore them
  for (genvar s = 0; s < MAX_STAGES; s++) begin : g_eff
    assign eff[s] = (STG_W'(s) < stagesQ) ? radixQ[s*RAD_W +: RAD_W] : RAD_W'(1);
  end

  // stride of a stage = product of the radices after it
  assign strideTab[MAX_STAGES-1] = (ADDR_W+1)'(1);
  for (genvar s = 0; s < MAX_STAGES-1; s++) begin : g_stride
    assign strideTab[s] = strideTab[s+1] * (ADDR_W+1)'(eff[s+1]);
  end

  assign totalSize = strideTab[0] * (ADDR_W+1)'(eff[0]);
  assign numStages = stagesQ;
  assign curRadix  = eff[stageSel];
  assign curStride = strideTab[stageSel];

endmodule

// File: rtl/mrfft_seq_ctrl.sv
module mrfft_seq_ctrl
  import mrfft_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RAD_W   = 3,
  parameter int STG_W   = 4,
  parameter int MOD_LAT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [STG_W-1:0] numStages,
  input  logic [RAD_W-1:0] curRadix,
  input  logic [ADDR_W:0]  curStride,
  input  logic [ADDR_W:0]  totalSize,
  output logic             load,
  output logic             busy,
  output logic             done,
  output logic [STG_W-1:0] stageIdx,
  output logic [RAD_W-1:0] kCnt,
  output logic [ADDR_W:0]  posCnt,
  output logic [ADDR_W:0]  blockBase,
  output seqStrobe_t       strobe
);

  localparam int GAP_LEN = MOD_LAT + 1;
  localparam int GW      = $clog2(GAP_LEN + 1);

  seqState_t       state;
  logic [GW-1:0]   gapCnt;
  logic [ADDR_W:0] span;
  logic            lastK, lastPos, lastBlock, finalStage;

  assign span       = curStride * (ADDR_W+1)'(curRadix);
  assign lastK      = (kCnt == curRadix - RAD_W'(1));
  assign lastPos    = (posCnt == curStride - (ADDR_W+1)'(1));
  assign lastBlock  = ({1'b0, blockBase} + {1'b0, span}) >= {1'b0, totalSize};
  assign finalStage = (stageIdx == numStages - STG_W'(1));

  assign busy = (state != ST_IDLE);
  assign load = start && (state == ST_IDLE);

  assign strobe.issue      = (state == ST_RUN);
  assign strobe.finalStage = finalStage;
  assign strobe.bankSel    = stageIdx[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      stageIdx  <= '0;
      kCnt      <= '0;
      posCnt    <= '0;
      blockBase <= '0;
      gapCnt    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state     <= ST_RUN;
            stageIdx  <= '0;
            kCnt      <= '0;
            posCnt    <= '0;
            blockBase <= '0;
          end
        end
        ST_RUN: begin
          if (lastK) begin
            kCnt <= '0;
            if (lastPos) begin
              posCnt <= '0;
              if (lastBlock) begin
                state  <= ST_GAP;
                gapCnt <= '0;
              end else begin
                blockBase <= blockBase + span;
              end
            end else begin
              posCnt <= posCnt + (ADDR_W+1)'(1);
            end
          end else begin
            kCnt <= kCnt + RAD_W'(1);
          end
        end
        ST_GAP: begin
          if (gapCnt == GW'(GAP_LEN - 1)) begin
            blockBase <= '0;
            if (finalStage) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end else begin
              state    <= ST_RUN;
              stageIdx <= stageIdx + STG_W'(1);
            end
          end else begin
            gapCnt <= gapCnt + GW'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4
  pos_in_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.issue |-> (posCnt < curStride));

  // R7
  gap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_GAP) |=> (state != ST_RUN) || (stageIdx != $past(stageIdx)));

endmodule

// File: rtl/mrfft_addr_dp.sv
module mrfft_addr_dp
  import mrfft_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int RAD_W   = 3,
  parameter int MOD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [RAD_W-1:0]  kCnt,
  input  logic [ADDR_W:0]   posCnt,
  input  logic [ADDR_W:0]   blockBase,
  input  logic [ADDR_W:0]   curStride,
  input  logic [ADDR_W:0]   totalSize,
  output logic              rdEn,
  output logic              rdBank,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] twIdx,
  output logic              wrEn,
  output logic              wrBank,
  output logic [ADDR_W-1:0] wrAddr
);

  // one read-latency cycle plus the arithmetic module latency
  localparam int DLY = MOD_LAT + 1;

  logic [ADDR_W:0]   rdAddrFull;
  logic [ADDR_W:0]   twFull;
  logic              vQ [DLY];
  logic              bQ [DLY];
  logic [ADDR_W-1:0] aQ [DLY];

  assign rdAddrFull = blockBase + posCnt + curStride * (ADDR_W+1)'(kCnt);
  assign twFull     = (ADDR_W+1)'(kCnt) * posCnt;

  assign rdEn   = strobe.issue;
  assign rdBank = strobe.bankSel;
  assign rdAddr = rdAddrFull[ADDR_W-1:0];
  assign twIdx  = strobe.finalStage ? '0 : twFull[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DLY; i++) begin
        vQ[i] <= 1'b0;
        bQ[i] <= 1'b0;
        aQ[i] <= '0;
      end
    end else begin
      vQ[0] <= strobe.issue;
      bQ[0] <= ~strobe.bankSel;
      aQ[0] <= rdAddr;
      for (int i = 1; i < DLY; i++) begin
        vQ[i] <= vQ[i-1];
        bQ[i] <= bQ[i-1];
        aQ[i] <= aQ[i-1];
      end
    end
  end

  assign wrEn   = vQ[DLY-1];
  assign wrBank = bQ[DLY-1];
  assign wrAddr = aQ[DLY-1];

  // R3
  rd_addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (rdAddrFull < totalSize));

  // R5
  bank_split_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && wrEn) |-> (rdBank != wrBank));

  // R8
  tw_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (twFull < totalSize));

  // R6
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> ({1'b0, wrAddr} < totalSize));

endmodule

// File: rtl/mrfft_addr_ctrl.sv
module mrfft_addr_ctrl
  import mrfft_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int MAX_STAGES = 13,
  parameter int MOD_LAT    = 2,
  localparam int RAD_W     = 3,
  localparam int STG_W     = $clog2(MAX_STAGES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [STG_W-1:0]            cfgStages,
  input  logic [MAX_STAGES*RAD_W-1:0] cfgRadix,
  output logic                        busy,
  output logic                        done,
  output logic                        rdEn,
  output logic                        rdBank,
  output logic [ADDR_W-1:0]           rdAddr,
  output logic [ADDR_W-1:0]           twIdx,
  output logic [STG_W-1:0]            stageIdx,
  output logic [RAD_W-1:0]            stageRadix,
  output logic                        wrEn,
  output logic                        wrBank,
  output logic [ADDR_W-1:0]           wrAddr
);

  logic             load;
  logic [STG_W-1:0] numStages;
  logic [RAD_W-1:0] curRadix;
  logic [ADDR_W:0]  curStride;
  logic [ADDR_W:0]  totalSize;
  logic [RAD_W-1:0] kCnt;
  logic [ADDR_W:0]  posCnt;
  logic [ADDR_W:0]  blockBase;
  seqStrobe_t       strobe;

  mrfft_stage_cfg #(
    .ADDR_W(ADDR_W), .MAX_STAGES(MAX_STAGES), .RAD_W(RAD_W), .STG_W(STG_W)
  ) u_cfg (
    .clk(clk), .rstN(rstN), .load(load),
    .cfgStages(cfgStages), .cfgRadix(cfgRadix), .stageSel(stageIdx),
    .numStages(numStages), .curRadix(curRadix),
    .curStride(curStride), .totalSize(totalSize)
  );

  mrfft_seq_ctrl #(
    .ADDR_W(ADDR_W), .RAD_W(RAD_W), .STG_W(STG_W), .MOD_LAT(MOD_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .numStages(numStages), .curRadix(curRadix),
    .curStride(curStride), .totalSize(totalSize),
    .load(load), .busy(busy), .done(done), .stageIdx(stageIdx),
    .kCnt(kCnt), .posCnt(posCnt), .blockBase(blockBase), .strobe(strobe)
  );

  mrfft_addr_dp #(
    .ADDR_W(ADDR_W), .RAD_W(RAD_W), .MOD_LAT(MOD_LAT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .kCnt(kCnt), .posCnt(posCnt), .blockBase(blockBase),
    .curStride(curStride), .totalSize(totalSize),
    .rdEn(rdEn), .rdBank(rdBank), .rdAddr(rdAddr), .twIdx(twIdx),
    .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr)
  );

  assign stageRadix = curRadix;

  // R11
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start) |=> ($stable(totalSize) && $stable(numStages)));

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && start) |=> (busy && rdEn));

endmodule

// File: tb/tb_mrfft_addr_ctrl.sv
`timescale 1ns/1ps
module tb_mrfft_addr_ctrl;

  localparam int ADDR_W     = 13;
  localparam int MAX_STAGES = 13;
  localparam int MOD_LAT    = 2;
  localparam int DLY        = MOD_LAT + 1;
  localparam int STG_W      = 4;

  logic                  clk;
  logic                  rstN;
  logic                  start;
  logic [STG_W-1:0]      cfgStages;
  logic [MAX_STAGES*3-1:0] cfgRadix;
  logic                  busy, done, rdEn, rdBank, wrEn, wrBank;
  logic [ADDR_W-1:0]     rdAddr, twIdx, wrAddr;
  logic [STG_W-1:0]      stageIdx;
  logic [2:0]            stageRadix;

  mrfft_addr_ctrl #(.ADDR_W(ADDR_W), .MAX_STAGES(MAX_STAGES), .MOD_LAT(MOD_LAT)) dut (
    .clk(clk), .rstN(rstN), .start(start), .cfgStages(cfgStages), .cfgRadix(cfgRadix),
    .busy(busy), .done(done), .rdEn(rdEn), .rdBank(rdBank), .rdAddr(rdAddr),
    .twIdx(twIdx), .stageIdx(stageIdx), .stageRadix(stageRadix),
    .wrEn(wrEn), .wrBank(wrBank), .wrAddr(wrAddr)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 0;
  bit ringV [8];
  int ringA [8];
  bit ringB [8];
  int radA [MAX_STAGES];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    cyc++;
  endtask

  task automatic cycleCheck(input bit expRd, input int expAddr, input int expTw,
                            input int expBank, input int expStage, input int expRad);
    int slot = cyc % 8;
    int old  = (cyc + 8 - DLY) % 8;
    chk(rdEn == expRd, "R4 rdEn", int'(rdEn), int'(expRd));
    if (expRd) begin
      chk(int'(rdAddr) == expAddr, "R3 rdAddr", int'(rdAddr), expAddr);
      chk(int'(rdBank) == expBank, "R5 rdBank", int'(rdBank), expBank);
      chk(int'(twIdx) == expTw, "R8 twIdx", int'(twIdx), expTw);
      chk(int'(stageIdx) == expStage, "R9 stageIdx", int'(stageIdx), expStage);
      chk(int'(stageRadix) == expRad, "R9 stageRadix", int'(stageRadix), expRad);
      chk(busy == 1'b1, "R2 busy during run", int'(busy), 1);
    end else begin
      // R7: quiet gap between stages, still busy, no done
      chk(busy == 1'b1 && done == 1'b0, "R7 gap busy/done", int'({busy, done}), 2);
    end
    if (cyc >= DLY && ringV[old]) begin
      chk(wrEn == 1'b1, "R6 wrEn", int'(wrEn), 1);
      chk(int'(wrAddr) == ringA[old], "R6 wrAddr", int'(wrAddr), ringA[old]);
      chk(wrBank == ringB[old], "R5 wrBank", int'(wrBank), int'(ringB[old]));
    end else begin
      chk(wrEn == 1'b0, "R6 wrEn idle", int'(wrEn), 0);
    end
    ringV[slot] = expRd;
    ringA[slot] = expAddr;
    ringB[slot] = (expBank == 0);
  endtask

  task automatic runCfg(input int n, input bit inject);
    int total = 1;
    int reads = 0;
    for (int j = 0; j < n; j++) total *= radA[j];
    cfgStages = STG_W'(n);
    cfgRadix  = '0;
    for (int j = 0; j < n; j++) cfgRadix[j*3 +: 3] = 3'(radA[j]);
    start = 1'b1;
    tick();
    start = 1'b0;
    cyc = 0;
    for (int i = 0; i < 8; i++) begin ringV[i] = 0; ringA[i] = 0; ringB[i] = 0; end
    // R2: first read at address 0 right after the start edge
    chk(rdEn && rdAddr == 0 && !rdBank, "R2 first read", int'(rdAddr), 0);
    for (int s = 0; s < n; s++) begin
      int stride = 1;
      int span;
      for (int j = s + 1; j < n; j++) stride *= radA[j];
      span = radA[s] * stride;
      for (int b = 0; b < total; b += span)
        for (int p = 0; p < stride; p++)
          for (int k = 0; k < radA[s]; k++) begin
            cycleCheck(1'b1, b + p + k * stride, (s == n - 1) ? 0 : k * p, s % 2, s, radA[s]);
            reads++;
            if (inject && reads == 5) begin
              // R11: start with a garbage configuration while busy
              start = 1'b1;
              cfgStages = 4'd1;
              cfgRadix = '1;
            end
            tick();
            if (inject && reads == 5) start = 1'b0;
          end
      for (int g = 0; g < DLY; g++) begin
        cycleCheck(1'b0, 0, 0, 0, 0, 0);
        tick();
      end
    end
    // R12: every stage read the full size
    chk(reads == n * total, "R12 read count", reads, n * total);
    chk(done == 1'b1, "R10 done pulse", int'(done), 1);
    chk(busy == 1'b0, "R10 busy low at done", int'(busy), 0);
    chk(wrEn == 1'b0 && rdEn == 1'b0, "R6 no traffic at done", int'({wrEn, rdEn}), 0);
    tick();
    chk(done == 1'b0, "R10 done one cycle", int'(done), 0);
    chk(busy == 1'b0 && rdEn == 1'b0, "R1 idle after run", int'({busy, rdEn}), 0);
  endtask

  initial begin
    rstN = 1'b0;
    start = 1'b0;
    cfgStages = '0;
    cfgRadix = '0;
    for (int j = 0; j < MAX_STAGES; j++) radA[j] = 0;
    @(negedge clk);
    @(negedge clk);
    chk({busy, done, rdEn, wrEn} == 4'b0, "R1 reset outputs", int'({busy, done, rdEn, wrEn}), 0);
    rstN = 1'b1;
    tick();
    tick();
    chk({busy, done, rdEn, wrEn} == 4'b0, "R1 idle after release", int'({busy, done, rdEn, wrEn}), 0);

    radA[0] = 2; radA[1] = 2; radA[2] = 2;
    runCfg(3, 1'b1);                                  // R11 injection
    radA[0] = 3; radA[1] = 5;
    runCfg(2, 1'b0);                                  // mixed seam
    radA[0] = 7;
    runCfg(1, 1'b0);                                  // single final stage, R8 zero twiddle
    radA[0] = 4; radA[1] = 3; radA[2] = 2;
    runCfg(3, 1'b0);
    radA[0] = 7; radA[1] = 5; radA[2] = 4; radA[3] = 3; radA[4] = 3; radA[5] = 3;
    runCfg(6, 1'b0);                                  // R12 3780 points
    for (int j = 0; j < 11; j++) radA[j] = 2;
    runCfg(11, 1'b0);                                 // R12 2048 points
    for (int j = 0; j < 6; j++) radA[j] = 4;
    runCfg(6, 1'b0);                                  // R12 4096 points

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule